// File: doc/BRIEF.md
# Host FIFO Port Decoder

This block sits between a 32-bit host bus and the four queues that carry Ethernet traffic to and from a MAC: an outgoing data queue, an incoming data queue, and two status queues, one for each direction. The block holds all four queues. Host reads and writes are single-cycle strobes with a byte address. The decoder maps each strobe onto one queue operation. Each data queue answers over a window of eight DWORD addresses, so an incrementing burst always lands in the queue. Each status queue has one address that removes its oldest word and a second address that only shows that word.

A direct-access input turns off the address map. While it is high, every write feeds the outgoing data queue and every read drains the incoming data queue. Only address bit 2 still matters, and its only job is to mark where one DWORD ends and the next begins. An endian input reverses the byte order of data-queue words in both directions. Status words are never reversed. On the MAC side, the MAC pushes incoming data and both kinds of status through valid/ready handshakes, and pops outgoing data the same way. Each queue reports its occupancy. Two sticky flags record reads of an empty queue and writes to a full one.

Top module: `hfifo_port`

## Requirements
- R1: After reset, all four occupancy counts are zero. Both sticky flags are low, `host_rdata` is zero, `txd_valid` is low and `rxd_ready` is high.
- R2: In normal mode, a read at any DWORD-aligned address from 0x00 to 0x1C returns the oldest incoming data word in the same cycle and removes it at the next clock edge. All eight aliases behave the same.
- R3: In normal mode, a write at any DWORD-aligned address from 0x20 to 0x3C appends `host_wdata` to the outgoing data queue. The MAC then receives the words in write order on `txd_data`, with `txd_valid` high.
- R4: A read at 0x40 returns the oldest incoming status word and removes it. A read at 0x48 does the same for outgoing status.
- R5: A read at 0x44 (incoming status) or 0x4C (outgoing status) returns the oldest word of that queue and leaves the queue unchanged.
- R6: While `direct_mode` is high, every write strobe targets the outgoing data queue and every read strobe targets the incoming data queue, whatever the address bits other than bit 2 hold.
- R7: While `direct_mode` is high, a strobe held over consecutive cycles moves one word only. A new word moves when the strobe is freshly asserted or when address bit 2 differs from its value in the previous strobe cycle. In cycles that move no word, `host_rdata` is zero.
- R8: When `big_endian` is high, data-queue words are byte-reversed in both directions: byte 0 swaps with byte 3, and byte 1 swaps with byte 2. Status words are never reversed. When `big_endian` is low, nothing is reordered.
- R9: A read of an empty queue through a data, pop or peek address returns zero and leaves the queue unchanged. From the next cycle on, `underrun_flag` is high and stays high until reset.
- R10: A write to the outgoing data queue while it is full drops the word. From the next cycle on, `overflow_flag` is high and stays high until reset.
- R11: Reads of unmapped addresses, of the 0x20 to 0x3C window, or of any address whose two low bits are not zero return zero with no effect. Writes outside 0x20 to 0x3C are ignored.
- R12: Occupancy counts stay exact when a push and a pop hit the same queue in the same cycle. `rxd_ready`, `rxs_ready` and `txs_ready` are low exactly when their queue is full. `txd_valid` is high exactly when the outgoing data queue holds a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| direct_mode | input | 1 | High selects direct queue access |
| big_endian | input | 1 | High byte-reverses data-queue words |
| host_addr | input | ADDR_W | Host byte address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid in the strobe cycle |
| rxd_valid | input | 1 | MAC offers an incoming data word |
| rxd_ready | output | 1 | Incoming data queue can accept |
| rxd_data | input | 32 | Incoming data word |
| rxs_valid | input | 1 | MAC offers an incoming status word |
| rxs_ready | output | 1 | Incoming status queue can accept |
| rxs_data | input | 32 | Incoming status word |
| txs_valid | input | 1 | MAC offers an outgoing status word |
| txs_ready | output | 1 | Outgoing status queue can accept |
| txs_data | input | 32 | Outgoing status word |
| txd_valid | output | 1 | Outgoing data word available to the MAC |
| txd_ready | input | 1 | MAC takes the outgoing data word |
| txd_data | output | 32 | Oldest outgoing data word |
| rxd_count | output | clog2(RXD_DEPTH+1) | Incoming data occupancy |
| rxs_count | output | clog2(RXS_DEPTH+1) | Incoming status occupancy |
| txd_count | output | clog2(TXD_DEPTH+1) | Outgoing data occupancy |
| txs_count | output | clog2(TXS_DEPTH+1) | Outgoing status occupancy |
| underrun_flag | output | 1 | Sticky: an empty queue was read |
| overflow_flag | output | 1 | Sticky: a full outgoing data queue was written |

## Verification
The bench builds the block with a DWORD-addressed 8-bit host address and small depths: four for both data queues, two for outgoing status and three for incoming status. With these depths, a handful of MAC pushes or host writes fills a queue. That makes the full condition, the dropped fifth write and the ready deassertion quick to reach. The outgoing data queue goes through several fill-and-drain rounds, so its pointers wrap many times. The non-power-of-two status depth exercises the explicit pointer wrap rather than a natural rollover.

// File: rtl/hfp_pkg.sv
// Package for the host FIFO port decoder.
// Holds the target encoding that the address decoder hands to the datapath.
package hfp_pkg;

    // Queue operation selected by one host strobe.
    typedef enum logic [2:0] {
        TGT_NONE     = 3'd0,
        TGT_RXD      = 3'd1,
        TGT_TXD      = 3'd2,
        TGT_RXS_POP  = 3'd3,
        TGT_RXS_PEEK = 3'd4,
        TGT_TXS_POP  = 3'd5,
        TGT_TXS_PEEK = 3'd6
    } tgt_e;

endpackage

// File: rtl/hfp_fifo.sv
// Synchronous single-clock queue with a show-ahead head word.
// Assumes: push is accepted only while not full and pop only while not empty,
// so callers may raise either strobe at any time. DEPTH need not be a power of two.
module hfp_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    // Derive status and the accepted operations.
    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        empty   = (count == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        head    = mem[rd_ptr];
    end

    // Store accepted words; storage needs no reset.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Advance pointers with an explicit wrap and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/hfp_swap.sv
// Byte-order converter for one 32-bit word.
// When swap is high the four bytes come out in reverse order; otherwise the word passes through.
module hfp_swap #(
    parameter int BYTES = 4,
    localparam int W = 8 * BYTES
) (
    input  logic         swap,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    // One lane per byte position.
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign dout[8*b +: 8] = swap ? din[8*(BYTES-1-b) +: 8] : din[8*b +: 8];
    end

endmodule

// File: rtl/hfp_decode.sv
// Host address decoder.
// Maps each host strobe onto one queue operation. Normal mode uses the address map;
// direct mode routes writes to outgoing data and reads from incoming data, and uses
// address bit 2 only to split a held strobe into DWORDs.
// Assumes: ADDR_W >= 7; addresses with nonzero low two bits map nowhere in normal mode.
module hfp_decode
    import hfp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              direct,
    output tgt_e              rd_tgt,
    output tgt_e              wr_tgt
);

    localparam int PAGE_W = ADDR_W - 5;
    localparam int STAT_W = ADDR_W - 4;

    logic prev_rd;
    logic prev_wr;
    logic prev_rd_a2;
    logic prev_wr_a2;
    logic rd_new;
    logic wr_new;
    logic aligned;
    logic in_rxd_win;
    logic in_txd_win;
    logic in_stat;

    // Remember the previous strobe cycle for burst delimiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_rd    <= 1'b0;
            prev_wr    <= 1'b0;
            prev_rd_a2 <= 1'b0;
            prev_wr_a2 <= 1'b0;
        end else begin
            prev_rd <= rd;
            prev_wr <= wr;
            if (rd) prev_rd_a2 <= addr[2];
            if (wr) prev_wr_a2 <= addr[2];
        end
    end

    // A fresh strobe or a toggled bit 2 starts a new DWORD.
    always_comb begin
        rd_new = !prev_rd || (addr[2] != prev_rd_a2);
        wr_new = !prev_wr || (addr[2] != prev_wr_a2);
    end

    // Classify the address against the normal-mode map.
    always_comb begin
        aligned    = (addr[1:0] == 2'b00);
        in_rxd_win = aligned && (addr[ADDR_W-1:5] == PAGE_W'(0));
        in_txd_win = aligned && (addr[ADDR_W-1:5] == PAGE_W'(1));
        in_stat    = aligned && (addr[ADDR_W-1:4] == STAT_W'(4));
    end

    // Select the read target.
    always_comb begin
        rd_tgt = TGT_NONE;
        if (rd) begin
            if (direct) begin
                rd_tgt = rd_new ? TGT_RXD : TGT_NONE;
            end else if (in_rxd_win) begin
                rd_tgt = TGT_RXD;
            end else if (in_stat) begin
                case (addr[3:2])
                    2'd0:    rd_tgt = TGT_RXS_POP;
                    2'd1:    rd_tgt = TGT_RXS_PEEK;
                    2'd2:    rd_tgt = TGT_TXS_POP;
                    default: rd_tgt = TGT_TXS_PEEK;
                endcase
            end
        end
    end

    // Select the write target.
    always_comb begin
        wr_tgt = TGT_NONE;
        if (wr) begin
            if (direct) begin
                wr_tgt = wr_new ? TGT_TXD : TGT_NONE;
            end else if (in_txd_win) begin
                wr_tgt = TGT_TXD;
            end
        end
    end

endmodule

// File: rtl/hfifo_port.sv
// Host FIFO port decoder, top level.
// Holds the four traffic queues, decodes host strobes onto them, applies the
// data-word byte order, and raises sticky underrun and overflow flags.
// Assumes: host_rdata is sampled in the strobe cycle; queue updates land at the next edge.
module hfifo_port
    import hfp_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int RXD_DEPTH = 512,
    parameter int RXS_DEPTH = 64,
    parameter int TXD_DEPTH = 512,
    parameter int TXS_DEPTH = 64,
    localparam int RXD_CW = $clog2(RXD_DEPTH + 1),
    localparam int RXS_CW = $clog2(RXS_DEPTH + 1),
    localparam int TXD_CW = $clog2(TXD_DEPTH + 1),
    localparam int TXS_CW = $clog2(TXS_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              direct_mode,
    input  logic              big_endian,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic              rxd_valid,
    output logic              rxd_ready,
    input  logic [31:0]       rxd_data,
    input  logic              rxs_valid,
    output logic              rxs_ready,
    input  logic [31:0]       rxs_data,
    input  logic              txs_valid,
    output logic              txs_ready,
    input  logic [31:0]       txs_data,
    output logic              txd_valid,
    input  logic              txd_ready,
    output logic [31:0]       txd_data,
    output logic [RXD_CW-1:0] rxd_count,
    output logic [RXS_CW-1:0] rxs_count,
    output logic [TXD_CW-1:0] txd_count,
    output logic [TXS_CW-1:0] txs_count,
    output logic              underrun_flag,
    output logic              overflow_flag
);

    tgt_e        rd_tgt;
    tgt_e        wr_tgt;
    logic [31:0] rxd_head;
    logic [31:0] rxd_host_word;
    logic [31:0] rxs_head;
    logic [31:0] txs_head;
    logic [31:0] txd_push_word;
    logic        rxd_full, rxd_empty;
    logic        rxs_full, rxs_empty;
    logic        txd_full, txd_empty;
    logic        txs_full, txs_empty;
    logic        rxd_pop, rxs_pop, txs_pop;
    logic        txd_push, txd_pop;
    logic        underrun_hit;
    logic        overflow_hit;

    hfp_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (host_addr),
        .rd     (host_rd),
        .wr     (host_wr),
        .direct (direct_mode),
        .rd_tgt (rd_tgt),
        .wr_tgt (wr_tgt)
    );

    hfp_swap #(.BYTES(4)) u_swap_in (
        .swap (big_endian),
        .din  (host_wdata),
        .dout (txd_push_word)
    );

    hfp_swap #(.BYTES(4)) u_swap_out (
        .swap (big_endian),
        .din  (rxd_head),
        .dout (rxd_host_word)
    );

    // Turn decoded targets and MAC handshakes into queue strobes.
    always_comb begin
        rxd_pop  = (rd_tgt == TGT_RXD);
        rxs_pop  = (rd_tgt == TGT_RXS_POP);
        txs_pop  = (rd_tgt == TGT_TXS_POP);
        txd_push = (wr_tgt == TGT_TXD);
        txd_pop  = txd_valid && txd_ready;
        rxd_ready = !rxd_full;
        rxs_ready = !rxs_full;
        txs_ready = !txs_full;
        txd_valid = !txd_empty;
    end

    // Steer the read data; empty queues and non-reads yield zero.
    always_comb begin
        case (rd_tgt)
            TGT_RXD:                   host_rdata = rxd_empty ? '0 : rxd_host_word;
            TGT_RXS_POP, TGT_RXS_PEEK: host_rdata = rxs_empty ? '0 : rxs_head;
            TGT_TXS_POP, TGT_TXS_PEEK: host_rdata = txs_empty ? '0 : txs_head;
            default:                   host_rdata = '0;
        endcase
    end

    // Detect error events for the sticky flags.
    always_comb begin
        underrun_hit = ((rd_tgt == TGT_RXD) && rxd_empty) ||
                       (((rd_tgt == TGT_RXS_POP) || (rd_tgt == TGT_RXS_PEEK)) && rxs_empty) ||
                       (((rd_tgt == TGT_TXS_POP) || (rd_tgt == TGT_TXS_PEEK)) && txs_empty);
        overflow_hit = txd_push && txd_full;
    end

    // Hold the error flags until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underrun_flag <= 1'b0;
            overflow_flag <= 1'b0;
        end else begin
            if (underrun_hit) underrun_flag <= 1'b1;
            if (overflow_hit) overflow_flag <= 1'b1;
        end
    end

    hfp_fifo #(.WIDTH(32), .DEPTH(RXD_DEPTH)) u_rxd_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rxd_valid),
        .push_data (rxd_data),
        .pop       (rxd_pop),
        .head      (rxd_head),
        .full      (rxd_full),
        .empty     (rxd_empty),
        .count     (rxd_count)
    );

    hfp_fifo #(.WIDTH(32), .DEPTH(RXS_DEPTH)) u_rxs_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rxs_valid),
        .push_data (rxs_data),
        .pop       (rxs_pop),
        .head      (rxs_head),
        .full      (rxs_full),
        .empty     (rxs_empty),
        .count     (rxs_count)
    );

    hfp_fifo #(.WIDTH(32), .DEPTH(TXD_DEPTH)) u_txd_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (txd_push),
        .push_data (txd_push_word),
        .pop       (txd_pop),
        .head      (txd_data),
        .full      (txd_full),
        .empty     (txd_empty),
        .count     (txd_count)
    );

    hfp_fifo #(.WIDTH(32), .DEPTH(TXS_DEPTH)) u_txs_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (txs_valid),
        .push_data (txs_data),
        .pop       (txs_pop),
        .head      (txs_head),
        .full      (txs_full),
        .empty     (txs_empty),
        .count     (txs_count)
    );

endmodule

// File: rtl/hfp_checks.sv
// Property checker for the host FIFO port decoder, attached by bind.
// Observes ports only and raises assertion failures on protocol breaches.
module hfp_checks #(
    parameter int ADDR_W    = 8,
    parameter int RXD_DEPTH = 512,
    parameter int RXS_DEPTH = 64,
    parameter int TXD_DEPTH = 512,
    localparam int RXD_CW = $clog2(RXD_DEPTH + 1),
    localparam int RXS_CW = $clog2(RXS_DEPTH + 1),
    localparam int TXD_CW = $clog2(TXD_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              direct_mode,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_rd,
    input logic [31:0]       host_rdata,
    input logic              rxd_ready,
    input logic              rxs_valid,
    input logic              rxs_ready,
    input logic              txd_valid,
    input logic [RXD_CW-1:0] rxd_count,
    input logic [RXS_CW-1:0] rxs_count,
    input logic [TXD_CW-1:0] txd_count,
    input logic              underrun_flag,
    input logic              overflow_flag
);

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_flag |=> overflow_flag); // R10

    AST_UNDR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_flag |=> underrun_flag); // R9

    AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !direct_mode && host_addr == ADDR_W'(8'h40) && rxs_count == '0)
        |-> (host_rdata == 32'h0)); // R9

    AST_EMPTY_POP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !direct_mode && host_addr == ADDR_W'(8'h40) && rxs_count == '0)
        |=> underrun_flag); // R9

    AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !direct_mode && host_addr == ADDR_W'(8'h44) && !(rxs_valid && rxs_ready))
        |=> (rxs_count == $past(rxs_count))); // R5

    AST_RXD_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rxd_count == RXD_CW'(RXD_DEPTH)) |-> !rxd_ready); // R12

    AST_TXD_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_count == '0) |-> !txd_valid); // R12

    AST_TXD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((txd_count == $past(txd_count)) ||
                  (txd_count == $past(txd_count) + 1'b1) ||
                  (txd_count + 1'b1 == $past(txd_count)))); // R12

    AST_TXD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        txd_count <= TXD_CW'(TXD_DEPTH)); // R10

endmodule

bind hfifo_port hfp_checks #(
    .ADDR_W    (ADDR_W),
    .RXD_DEPTH (RXD_DEPTH),
    .RXS_DEPTH (RXS_DEPTH),
    .TXD_DEPTH (TXD_DEPTH)
) u_hfp_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .direct_mode   (direct_mode),
    .host_addr     (host_addr),
    .host_rd       (host_rd),
    .host_rdata    (host_rdata),
    .rxd_ready     (rxd_ready),
    .rxs_valid     (rxs_valid),
    .rxs_ready     (rxs_ready),
    .txd_valid     (txd_valid),
    .rxd_count     (rxd_count),
    .rxs_count     (rxs_count),
    .txd_count     (txd_count),
    .underrun_flag (underrun_flag),
    .overflow_flag (overflow_flag)
);

// File: tb/hfifo_port_bench.sv
// Self-checking bench for hfifo_port: a vector table for the address map,
// then directed tests for reset, errors, simultaneity, byte order and direct mode.
module hfifo_port_bench;

    localparam int ADDR_W = 8;
    localparam int RXD_D  = 4;
    localparam int RXS_D  = 3;
    localparam int TXD_D  = 4;
    localparam int TXS_D  = 2;

    localparam logic [31:0] D0 = 32'hA000_0001;
    localparam logic [31:0] D1 = 32'hA000_0002;
    localparam logic [31:0] D2 = 32'hA000_0003;
    localparam logic [31:0] D3 = 32'hA000_0004;
    localparam logic [31:0] S0 = 32'h5500_0010;
    localparam logic [31:0] S1 = 32'h5500_0011;
    localparam logic [31:0] T0 = 32'h7700_0020;
    localparam logic [31:0] T1 = 32'h7700_0021;
    localparam logic [31:0] W0 = 32'hC0DE_0001;
    localparam logic [31:0] W1 = 32'hC0DE_0002;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 8'h00, 32'h0, D0},   // R2 base of incoming data window
        '{1'b1, 1'b0, 8'h1C, 32'h0, D1},   // R2 last alias
        '{1'b1, 1'b0, 8'h44, 32'h0, S0},   // R5 peek
        '{1'b1, 1'b0, 8'h44, 32'h0, S0},   // R5 peek again, same word
        '{1'b1, 1'b0, 8'h40, 32'h0, S0},   // R4 pop
        '{1'b1, 1'b0, 8'h44, 32'h0, S1},   // R4 next word now at head
        '{1'b1, 1'b0, 8'h4C, 32'h0, T0},   // R5 outgoing status peek
        '{1'b1, 1'b0, 8'h48, 32'h0, T0},   // R4 outgoing status pop
        '{1'b1, 1'b0, 8'h48, 32'h0, T1},   // R4 second pop
        '{1'b1, 1'b0, 8'h50, 32'h0, 32'h0},// R11 unmapped read
        '{1'b1, 1'b0, 8'h20, 32'h0, 32'h0},// R11 outgoing data window read
        '{1'b0, 1'b1, 8'h20, W0,    32'h0},// R3 write base
        '{1'b0, 1'b1, 8'h3C, W1,    32'h0},// R3 write last alias
        '{1'b1, 1'b0, 8'h0C, 32'h0, D2}    // R2 middle alias
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              direct_mode = 1'b0;
    logic              big_endian = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic              host_rd = 1'b0;
    logic              host_wr = 1'b0;
    logic [31:0]       host_wdata = '0;
    logic [31:0]       host_rdata;
    logic              rxd_valid = 1'b0;
    logic              rxd_ready;
    logic [31:0]       rxd_data = '0;
    logic              rxs_valid = 1'b0;
    logic              rxs_ready;
    logic [31:0]       rxs_data = '0;
    logic              txs_valid = 1'b0;
    logic              txs_ready;
    logic [31:0]       txs_data = '0;
    logic              txd_valid;
    logic              txd_ready = 1'b0;
    logic [31:0]       txd_data;
    logic [2:0]        rxd_count;
    logic [1:0]        rxs_count;
    logic [2:0]        txd_count;
    logic [1:0]        txs_count;
    logic              underrun_flag;
    logic              overflow_flag;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    hfifo_port #(
        .ADDR_W    (ADDR_W),
        .RXD_DEPTH (RXD_D),
        .RXS_DEPTH (RXS_D),
        .TXD_DEPTH (TXD_D),
        .TXS_DEPTH (TXS_D)
    ) u_hfifo_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .direct_mode   (direct_mode),
        .big_endian    (big_endian),
        .host_addr     (host_addr),
        .host_rd       (host_rd),
        .host_wr       (host_wr),
        .host_wdata    (host_wdata),
        .host_rdata    (host_rdata),
        .rxd_valid     (rxd_valid),
        .rxd_ready     (rxd_ready),
        .rxd_data      (rxd_data),
        .rxs_valid     (rxs_valid),
        .rxs_ready     (rxs_ready),
        .rxs_data      (rxs_data),
        .txs_valid     (txs_valid),
        .txs_ready     (txs_ready),
        .txs_data      (txs_data),
        .txd_valid     (txd_valid),
        .txd_ready     (txd_ready),
        .txd_data      (txd_data),
        .rxd_count     (rxd_count),
        .rxs_count     (rxs_count),
        .txd_count     (txd_count),
        .txs_count     (txs_count),
        .underrun_flag (underrun_flag),
        .overflow_flag (overflow_flag)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One host strobe cycle: drive after the falling edge, settle before the rising edge.
    task automatic cyc(input logic rd, input logic wr, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_rd = rd;
        host_wr = wr;
        host_addr = a;
        host_wdata = d;
        #2;
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 8'h00, 32'h0);
    endtask

    task automatic push_rxd(input logic [31:0] d);
        @(negedge clk);
        rxd_valid = 1'b1;
        rxd_data = d;
        @(negedge clk);
        rxd_valid = 1'b0;
    endtask

    task automatic push_rxs(input logic [31:0] d);
        @(negedge clk);
        rxs_valid = 1'b1;
        rxs_data = d;
        @(negedge clk);
        rxs_valid = 1'b0;
    endtask

    task automatic push_txs(input logic [31:0] d);
        @(negedge clk);
        txs_valid = 1'b1;
        txs_data = d;
        @(negedge clk);
        txs_valid = 1'b0;
    endtask

    // MAC pop of one outgoing word with expected value.
    task automatic pop_txd(input string tag, input logic [31:0] exp);
        @(negedge clk);
        #1;
        check(tag, {31'h0, txd_valid}, 32'h1);
        check(tag, txd_data, exp);
        txd_ready = 1'b1;
        @(negedge clk);
        txd_ready = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check("R1 rxd_count", 32'(rxd_count), 32'h0);
        check("R1 txd_count", 32'(txd_count), 32'h0);
        check("R1 flags", {30'h0, underrun_flag, overflow_flag}, 32'h0);
        check("R1 rdata", host_rdata, 32'h0);
        check("R1 handshakes", {30'h0, txd_valid, rxd_ready}, 32'h1);
        rst_n = 1'b1;

        // Preload; the incoming data queue ends full.
        push_rxd(D0); push_rxd(D1); push_rxd(D2); push_rxd(D3);
        check("R12 rxd_ready low when full", {31'h0, rxd_ready}, 32'h0);
        check("R12 rxd_count full", 32'(rxd_count), 32'd4);
        push_rxs(S0); push_rxs(S1);
        push_txs(T0); push_txs(T1);
        check("R12 txs_ready low when full", {31'h0, txs_ready}, 32'h0);

        // Address map vectors.
        for (int i = 0; i < NVEC; i++) begin
            cyc(VECS[i].rd, VECS[i].wr, VECS[i].addr, VECS[i].wdata);
            check($sformatf("vector %0d addr %h", i, VECS[i].addr), host_rdata, VECS[i].exp);
        end
        idle();
        check("R5 rxs_count after peeks and one pop", 32'(rxs_count), 32'd1);
        pop_txd("R3 first written word", W0);
        pop_txd("R3 second written word", W1);
        check("R12 txd_valid low when empty", {31'h0, txd_valid}, 32'h0);
        check("R9 no underrun yet", {31'h0, underrun_flag}, 32'h0);

        // R9 empty peek.
        cyc(1'b1, 1'b0, 8'h4C, 32'h0);
        check("R9 empty peek data", host_rdata, 32'h0);
        idle();
        check("R9 underrun set", {31'h0, underrun_flag}, 32'h1);
        check("R9 txs_count unchanged", 32'(txs_count), 32'h0);

        // R11 ignored writes and misaligned read.
        cyc(1'b0, 1'b1, 8'h00, 32'hDEAD_0000);
        cyc(1'b0, 1'b1, 8'h40, 32'hDEAD_0001);
        cyc(1'b0, 1'b1, 8'h50, 32'hDEAD_0002);
        cyc(1'b0, 1'b1, 8'h22, 32'hDEAD_0003);
        cyc(1'b1, 1'b0, 8'h41, 32'h0);
        check("R11 misaligned read", host_rdata, 32'h0);
        idle();
        check("R11 counts untouched", {8'h0, 5'(rxd_count), 5'(rxs_count), 5'(txd_count), 9'(txs_count)},
              {8'h0, 5'd1, 5'd1, 5'd0, 9'd0});
        cyc(1'b1, 1'b0, 8'h40, 32'h0);
        check("R4 pop remaining incoming status", host_rdata, S1);
        cyc(1'b1, 1'b0, 8'h10, 32'h0);
        check("R2 last incoming data word", host_rdata, D3);
        idle();
        check("R2 rxd drained", 32'(rxd_count), 32'h0);

        // R10 overflow: five writes into a depth-four queue.
        for (int i = 0; i < 5; i++) begin
            cyc(1'b0, 1'b1, 8'(8'h20 + 4 * i), 32'hB000_0000 + 32'(i));
        end
        idle();
        check("R10 overflow set", {31'h0, overflow_flag}, 32'h1);
        check("R10 txd_count capped", 32'(txd_count), 32'd4);
        for (int i = 0; i < 4; i++) begin
            pop_txd("R10 kept words in order", 32'hB000_0000 + 32'(i));
        end
        check("R10 dropped word absent", {31'h0, txd_valid}, 32'h0);

        // R12 simultaneous push and pop on the outgoing data queue.
        cyc(1'b0, 1'b1, 8'h20, 32'hE000_0000);
        cyc(1'b0, 1'b1, 8'h24, 32'hE000_0001);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 8'h28; host_wdata = 32'hE000_0002;
        txd_ready = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; txd_ready = 1'b0;
        #1;
        check("R12 txd_count with push and pop", 32'(txd_count), 32'd2);
        pop_txd("R12 order after overlap", 32'hE000_0001);
        pop_txd("R12 order after overlap", 32'hE000_0002);

        // R12 simultaneous MAC push and host pop on incoming data.
        push_rxd(32'hF000_0000);
        @(negedge clk);
        rxd_valid = 1'b1; rxd_data = 32'hF000_0001;
        host_rd = 1'b1; host_addr = 8'h04;
        #2;
        check("R12 read during push", host_rdata, 32'hF000_0000);
        @(negedge clk);
        rxd_valid = 1'b0; host_rd = 1'b0;
        #1;
        check("R12 rxd_count with push and pop", 32'(rxd_count), 32'd1);
        cyc(1'b1, 1'b0, 8'h08, 32'h0);
        check("R12 second word", host_rdata, 32'hF000_0001);
        idle();

        // R8 byte order.
        big_endian = 1'b1;
        cyc(1'b0, 1'b1, 8'h20, 32'h1122_3344);
        idle();
        pop_txd("R8 write reversed", 32'h4433_2211);
        push_rxd(32'hAABB_CCDD);
        cyc(1'b1, 1'b0, 8'h00, 32'h0);
        check("R8 read reversed", host_rdata, 32'hDDCC_BBAA);
        push_rxs(32'h0102_0304);
        cyc(1'b1, 1'b0, 8'h40, 32'h0);
        check("R8 status not reversed", host_rdata, 32'h0102_0304);
        idle();
        big_endian = 1'b0;

        // R6 and R7 direct mode.
        direct_mode = 1'b1;
        push_rxd(32'h9000_0000); push_rxd(32'h9000_0001); push_rxd(32'h9000_0002);
        cyc(1'b1, 1'b0, 8'h48, 32'h0);
        check("R6 direct read ignores status address", host_rdata, 32'h9000_0000);
        cyc(1'b1, 1'b0, 8'h48, 32'h0);
        check("R7 held strobe moves no word", host_rdata, 32'h0);
        cyc(1'b1, 1'b0, 8'h4C, 32'h0);
        check("R7 bit 2 toggle moves next word", host_rdata, 32'h9000_0001);
        idle();
        check("R7 two words taken", 32'(rxd_count), 32'd1);
        cyc(1'b1, 1'b0, 8'hF8, 32'h0);
        check("R6 direct read high address", host_rdata, 32'h9000_0002);
        idle();
        cyc(1'b0, 1'b1, 8'h40, 32'h6000_0000);
        cyc(1'b0, 1'b1, 8'h40, 32'h6000_00FF);
        cyc(1'b0, 1'b1, 8'h44, 32'h6000_0001);
        idle();
        check("R7 held write counted once", 32'(txd_count), 32'd2);
        pop_txd("R6 direct write to outgoing data", 32'h6000_0000);
        pop_txd("R6 direct write to outgoing data", 32'h6000_0001);
        direct_mode = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule